// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block chooses which pending UART interrupt source to report and builds the word that software reads from the interrupt identification register. It takes five source conditions: receive line status, receive data available, character time-out, transmit holding empty and modem status. It also takes two auto-baud event pulses, the per-source enable bits, the FIFO enable control bit, a read strobe and two auto-baud clear strobes. From these it produces a registered 32-bit identification word and one combined interrupt request line.

The transmit holding empty source arrives as an event pulse and is held in a pending latch. Reading the register while that source is the one reported clears the latch. The other four sources are levels, and their own logic clears them. The two auto-baud outcomes (finished, timed out) are sticky flags that sit beside the prioritized code.

While a read is in progress the reported word does not change. State that changes during the read is recorded internally and appears once the read strobe drops. The bus decoder routes the auto-baud enables (bits 8 and 9 of the enable register) and the source enables (bits 3:0) to separate ports.

Top module: `uart_irq_ident`

## Requirements
- R1: `id_word[0]` is 0 when at least one enabled non-auto-baud source is pending, and 1 when none is pending.
- R2: When `id_word[0]` is 1, `id_word[3:1]` is 000.
- R3: `id_word[3:1]` reports the highest-priority enabled pending source, in this order from highest to lowest:
  - 011: line status, enabled by `src_en[2]`.
  - 010: receive data available, enabled by `src_en[0]`.
  - 110: character time-out, also enabled by `src_en[0]`. When it and receive data available are both pending, 010 is reported.
  - 001: transmit holding empty, enabled by `src_en[1]`.
  - 000: modem status, enabled by `src_en[3]`.
  
  While `id_rd` is low, the word captures the level inputs at each clock edge.
- R4: The codes 100, 101 and 111 never appear in `id_word[3:1]`.
- R5: Bits 7 and 6 of `id_word` both equal `fifo_en` as sampled at the capturing edge.
- R6: Auto-baud flags:
  - Bit 8 (finished) is set by `ab_done_evt` only while `ab_en[0]` is 1.
  - Bit 9 (timed out) is set by `ab_tmo_evt` only while `ab_en[1]` is 1.
  - A flag set at an edge is visible in `id_word` one edge later.
- R7: Each auto-baud flag stays set until its clear strobe (`ab_done_clr` or `ab_tmo_clr`). An event in the same cycle as its clear leaves the flag set.
- R8: `id_word` holds its value at every edge where `id_rd` is 1. Events during the read appear after `id_rd` returns to 0.
- R9: After reset `id_word` is 0x00000001, and bits 31:10 are always 0.
- R10: `irq` is 1 exactly when `id_word[0]` is 0, or `id_word[8]` is 1, or `id_word[9]` is 1.
- R11: A `thre_evt` pulse sets a transmit-holding-empty pending latch. At the first edge of a read (`id_rd` rising), the latch is cleared if the held word reports code 001 with `id_word[0]`=0. A `thre_evt` in that same cycle keeps the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rls_cond | input | 1 | Receive line status condition (level) |
| rda_cond | input | 1 | Receive data available condition (level) |
| cti_cond | input | 1 | Character time-out condition (level) |
| thre_evt | input | 1 | Transmit holding empty event (pulse) |
| modem_cond | input | 1 | Modem status condition (level) |
| ab_done_evt | input | 1 | Auto-baud finished event (pulse) |
| ab_tmo_evt | input | 1 | Auto-baud time-out event (pulse) |
| src_en | input | 4 | Source enables: [0] rx data/time-out, [1] tx empty, [2] line status, [3] modem |
| ab_en | input | 2 | Auto-baud enables: [0] finished, [1] time-out |
| fifo_en | input | 1 | FIFO enable control bit |
| id_rd | input | 1 | Identification register read in progress |
| ab_done_clr | input | 1 | Clear strobe for the finished flag |
| ab_tmo_clr | input | 1 | Clear strobe for the time-out flag |
| id_word | output | 32 | Identification word |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is an event that lands inside a multi-cycle read. The word must stay frozen for the whole read and only then show the event. The transmit-empty latch must be cleared only when its code was the one held at the start of the read. The random stimulus holds `id_rd` high for one to four cycles, forces a low cycle between reads, and fires auto-baud, clear and transmit pulses at random against a cycle-accurate bench model. Directed sequences also place an auto-baud event in the middle of a read and a `thre_evt` on the exact edge of a clearing read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [2:0] ID_RLS   = 3'b011;
  localparam logic [2:0] ID_RDA   = 3'b010;
  localparam logic [2:0] ID_CTI   = 3'b110;
  localparam logic [2:0] ID_THRE  = 3'b001;
  localparam logic [2:0] ID_MODEM = 3'b000;

  typedef struct packed {
    logic       idle;   // 1 = nothing pending (active-low pending flag)
    logic [2:0] code;
  } ident_t;

  // Priority pick over the gated source conditions.
  function automatic ident_t pick_source(input logic rls, input logic rda,
                                         input logic cti, input logic thre,
                                         input logic modem);
    ident_t r;
    r.idle = 1'b0;
    if (rls)        r.code = ID_RLS;
    else if (rda)   r.code = ID_RDA;
    else if (cti)   r.code = ID_CTI;
    else if (thre)  r.code = ID_THRE;
    else if (modem) r.code = ID_MODEM;
    else begin
      r.idle = 1'b1;
      r.code = 3'b000;
    end
    return r;
  endfunction

  function automatic logic code_reserved(input logic [2:0] c);
    return (c == 3'b100) || (c == 3'b101) || (c == 3'b111);
  endfunction

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       rls_cond,
  input  logic       rda_cond,
  input  logic       cti_cond,
  input  logic       thre_pend,
  input  logic       modem_cond,
  input  logic [3:0] src_en,
  output ident_t     ident
);
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_RLS   = 2;
  localparam int EN_MODEM = 3;

  logic g_rls, g_rda, g_cti, g_thre, g_modem;

  assign g_rls   = rls_cond   & src_en[EN_RLS];
  assign g_rda   = rda_cond   & src_en[EN_RX];
  assign g_cti   = cti_cond   & src_en[EN_RX];
  assign g_thre  = thre_pend  & src_en[EN_THRE];
  assign g_modem = modem_cond & src_en[EN_MODEM];

  always_comb begin
    ident = pick_source(g_rls, g_rda, g_cti, g_thre, g_modem);
  end
endmodule

// File: rtl/uart_irq_ab_flags.sv
module uart_irq_ab_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  logic [N-1:0] set_req;
  assign set_req = evt & en;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag[i] <= 1'b0;
      else if (set_req[i]) flag[i] <= 1'b1;
      else if (clr[i])     flag[i] <= 1'b0;
    end

    AST_AB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);                    // R7
    AST_AB_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[i] && !(evt[i] && en[i])) |=> !flag[i]);       // R6
  end
endmodule

// File: rtl/uart_irq_thre_latch.sv
module uart_irq_thre_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_evt) pend <= 1'b1;
    else if (clr_req) pend <= 1'b0;
  end

  AST_THRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !pend);                       // R11
  AST_THRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);                                      // R11
endmodule

// File: rtl/uart_irq_hold.sv
module uart_irq_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic [W-1:0] live,
  output logic [W-1:0] word,
  output logic         rd_start
);
  localparam logic [W-1:0] RST_WORD = {{(W-1){1'b0}}, 1'b1};

  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= RST_WORD;
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd;
      if (!rd) word <= live;
    end
  end

  assign rd_start = rd & ~rd_q;

  AST_FROZEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> $stable(word));                                  // R8
  AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_irq_pkg::code_reserved(word[3:1]));               // R4
  AST_IDLE_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word[0] |-> (word[3:1] == 3'b000));                     // R2
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int AB_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rls_cond,
  input  logic              rda_cond,
  input  logic              cti_cond,
  input  logic              thre_evt,
  input  logic              modem_cond,
  input  logic              ab_done_evt,
  input  logic              ab_tmo_evt,
  input  logic [3:0]        src_en,
  input  logic [AB_N-1:0]   ab_en,
  input  logic              fifo_en,
  input  logic              id_rd,
  input  logic              ab_done_clr,
  input  logic              ab_tmo_clr,
  output logic [WORD_W-1:0] id_word,
  output logic              irq
);
  localparam int POS_FIFO_LO = 6;
  localparam int POS_FIFO_HI = 7;
  localparam int POS_AB      = 8;
  localparam int POS_TOP     = POS_AB + AB_N;

  ident_t            ident;
  logic              thre_pend;
  logic              thre_clr_req;
  logic              rd_start;
  logic [AB_N-1:0]   ab_flag;
  logic [WORD_W-1:0] live_word;

  uart_irq_prio u_prio (
    .rls_cond   (rls_cond),
    .rda_cond   (rda_cond),
    .cti_cond   (cti_cond),
    .thre_pend  (thre_pend),
    .modem_cond (modem_cond),
    .src_en     (src_en),
    .ident      (ident)
  );

  uart_irq_ab_flags #(.N(AB_N)) u_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   ({ab_tmo_evt, ab_done_evt}),
    .en    (ab_en),
    .clr   ({ab_tmo_clr, ab_done_clr}),
    .flag  (ab_flag)
  );

  // Clear only when the word held at the start of the read names tx empty.
  assign thre_clr_req = rd_start & ~id_word[0] & (id_word[3:1] == ID_THRE);

  uart_irq_thre_latch u_thre (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (thre_evt),
    .clr_req (thre_clr_req),
    .pend    (thre_pend)
  );

  always_comb begin
    live_word                        = '0;
    live_word[0]                     = ident.idle;
    live_word[3:1]                   = ident.code;
    live_word[POS_FIFO_HI:POS_FIFO_LO] = {2{fifo_en}};
    live_word[POS_TOP-1:POS_AB]      = ab_flag;
  end

  uart_irq_hold #(.W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (id_rd),
    .live     (live_word),
    .word     (id_word),
    .rd_start (rd_start)
  );

  assign irq = ~id_word[0] | (|id_word[POS_TOP-1:POS_AB]);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    id_word[WORD_W-1:POS_TOP] == '0);                        // R9
  AST_FIFO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    !id_rd |=> (id_word[POS_FIFO_HI:POS_FIFO_LO] == {2{$past(fifo_en)}})); // R5
  AST_PEND_WHEN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_rd && rls_cond && src_en[2]) |=> (id_word[3:0] == 4'b0110)); // R3
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rls_cond = 0, rda_cond = 0, cti_cond = 0, thre_evt = 0, modem_cond = 0;
  logic        ab_done_evt = 0, ab_tmo_evt = 0;
  logic [3:0]  src_en = '0;
  logic [1:0]  ab_en = '0;
  logic        fifo_en = 0, id_rd = 0, ab_done_clr = 0, ab_tmo_clr = 0;
  logic [31:0] id_word;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .rls_cond(rls_cond), .rda_cond(rda_cond),
    .cti_cond(cti_cond), .thre_evt(thre_evt), .modem_cond(modem_cond),
    .ab_done_evt(ab_done_evt), .ab_tmo_evt(ab_tmo_evt), .src_en(src_en),
    .ab_en(ab_en), .fifo_en(fifo_en), .id_rd(id_rd), .ab_done_clr(ab_done_clr),
    .ab_tmo_clr(ab_tmo_clr), .id_word(id_word), .irq(irq)
  );

  // ---------------- bench model ----------------
  logic [31:0] m_word = 32'h1;
  logic        m_thre = 0, m_done = 0, m_tmo = 0, m_rdq = 0;

  // Rank-based restatement of the priority rule (R3).
  function automatic logic [3:0] exp_low(input logic rl, rd, ct, th, mo, input logic [3:0] en);
    logic [4:0] act;
    act = {mo & en[3], th & en[1], ct & en[0], rd & en[0], rl & en[2]};
    if (act == 5'b0)  return 4'b0001;
    if (act[0])       return {3'b011, 1'b0};
    if (act[1])       return {3'b010, 1'b0};
    if (act[2])       return {3'b110, 1'b0};
    if (act[3])       return {3'b001, 1'b0};
    return 4'b0000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = 32'h1; m_thre = 0; m_done = 0; m_tmo = 0; m_rdq = 0;
    end else begin
      logic start;
      logic [31:0] lw;
      start = id_rd && !m_rdq;
      lw = 32'h0;
      lw[3:0] = exp_low(rls_cond, rda_cond, cti_cond, m_thre, modem_cond, src_en);
      lw[7:6] = {fifo_en, fifo_en};
      lw[8]   = m_done;
      lw[9]   = m_tmo;
      if (start && m_word[3:0] == 4'b0010 && !thre_evt) m_thre = 0;
      if (thre_evt) m_thre = 1;
      if (!id_rd) m_word = lw;
      if (ab_done_evt && ab_en[0]) m_done = 1; else if (ab_done_clr) m_done = 0;
      if (ab_tmo_evt && ab_en[1])  m_tmo  = 1; else if (ab_tmo_clr)  m_tmo  = 0;
      m_rdq = id_rd;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    logic e_irq;
    e_irq = !m_word[0] || m_word[8] || m_word[9];
    chk(id_word[0] == m_word[0], "R1", {31'b0, id_word[0]}, {31'b0, m_word[0]});
    chk(id_word[3:1] == m_word[3:1], "R3", {29'b0, id_word[3:1]}, {29'b0, m_word[3:1]});
    chk(!(id_word[3:1] inside {3'b100, 3'b101, 3'b111}), "R4", {29'b0, id_word[3:1]}, 32'h0);
    chk(id_word[7:6] == m_word[7:6], "R5", {30'b0, id_word[7:6]}, {30'b0, m_word[7:6]});
    chk(id_word[9:8] == m_word[9:8], "R6", {30'b0, id_word[9:8]}, {30'b0, m_word[9:8]});
    chk(id_word[31:10] == 22'b0, "R9", id_word, m_word);
    chk(irq == e_irq, "R10", {31'b0, irq}, {31'b0, e_irq});
  endtask

  task automatic quiet();
    rls_cond = 0; rda_cond = 0; cti_cond = 0; thre_evt = 0; modem_cond = 0;
    ab_done_evt = 0; ab_tmo_evt = 0; ab_done_clr = 0; ab_tmo_clr = 0; id_rd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    cmp_all();
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    int rd_left;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset value
    chk(id_word == 32'h1, "R9", id_word, 32'h1);
    chk(irq == 1'b0, "R10", {31'b0, irq}, 32'h0);
    rst_n = 1;
    step();

    // R3: rx data and time-out together -> 010
    src_en = 4'hF; rda_cond = 1; cti_cond = 1;
    step();
    chk(id_word[3:0] == 4'b0100, "R3", {28'b0, id_word[3:0]}, 32'h4);
    quiet(); src_en = 4'h0; rls_cond = 1; modem_cond = 1;
    step();
    // R2: sources disabled, idle field zero
    chk(id_word[3:0] == 4'b0001, "R2", {28'b0, id_word[3:0]}, 32'h1);
    quiet();

    // R6: disabled event does not set
    ab_en = 2'b00; ab_done_evt = 1; ab_tmo_evt = 1;
    step(); quiet(); step();
    chk(id_word[9:8] == 2'b00, "R6", {30'b0, id_word[9:8]}, 32'h0);

    // R8: event during a read shows only after it
    ab_en = 2'b11; id_rd = 1; ab_done_evt = 1;
    step(); held = id_word; ab_done_evt = 0;
    step();
    chk(id_word == held && id_word[8] == 0, "R8", id_word, held);
    id_rd = 0;
    step();
    chk(id_word[8] == 1'b1, "R8", {31'b0, id_word[8]}, 32'h1);

    // R7: event with clear in same cycle keeps flag, clear alone drops it
    ab_done_clr = 1; ab_done_evt = 1;
    step(); quiet(); step();
    chk(id_word[8] == 1'b1, "R7", {31'b0, id_word[8]}, 32'h1);
    ab_done_clr = 1;
    step(); quiet(); step();
    chk(id_word[8] == 1'b0, "R7", {31'b0, id_word[8]}, 32'h0);

    // R11: tx empty reported, cleared by the read
    src_en = 4'h2; thre_evt = 1;
    step(); thre_evt = 0; step();
    chk(id_word[3:0] == 4'b0010, "R11", {28'b0, id_word[3:0]}, 32'h2);
    id_rd = 1; step(); id_rd = 0; step();
    chk(id_word[0] == 1'b1, "R11", {31'b0, id_word[0]}, 32'h1);
    // R11: new event on the clearing edge keeps it
    thre_evt = 1; step(); thre_evt = 0; step();
    id_rd = 1; thre_evt = 1; step(); quiet(); step();
    chk(id_word[3:0] == 4'b0010, "R11", {28'b0, id_word[3:0]}, 32'h2);
    id_rd = 1; step(); quiet(); step();

    // constrained random
    rd_left = 0;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      rls_cond    = (r[3:0] == 0);
      rda_cond    = r[4] & r[5];
      cti_cond    = r[6] & r[7];
      thre_evt    = (r[11:8] == 0);
      modem_cond  = r[12] & r[13] & r[14];
      ab_done_evt = (r[18:15] == 0);
      ab_tmo_evt  = (r[22:19] == 0);
      ab_done_clr = (r[25:23] == 0);
      ab_tmo_clr  = (r[28:26] == 0);
      if (r[31:29] == 0) src_en = 4'($urandom);
      if (r[30:28] == 3'b111) ab_en = 2'($urandom);
      if (r[31:27] == 5'b10101) fifo_en = ~fifo_en;
      if (rd_left > 0) begin
        id_rd = 1; rd_left--;
      end else if (id_rd) begin
        id_rd = 0;
      end else if ((r & 32'h7) == 32'h5) begin
        id_rd = 1; rd_left = int'($urandom_range(3, 0));
      end
      held = id_word;
      step();
      if (id_rd && u0.id_rd) chk(id_word == held, "R8", id_word, held);
    end
    quiet();
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule